// File: doc/BRIEF.md
# One-Shot Operand Override Unit

This block sits in the operand path of an accumulator processor. It adds two prefix instructions. The register prefix captures the value of its addressed file register. The literal prefix captures an immediate taken from its own opcode. In both cases the captured value goes into a one-entry operand buffer. The instruction in the next valid execute slot takes its file operand from that buffer and does not read the register file. Once that slot has passed, the buffer is empty again.

The unit also decodes a move that writes its operand to the destination register and leaves every status flag alone. A prefix followed by this move copies one register to another, or loads a constant into a register. The copy changes neither the accumulator nor the status register. The unit produces the operand that goes to the ALU. It also produces a small result path for the add and move kinds and the write enables for the destination, the accumulator and the flags. While the buffer is armed it blocks interrupt entry, so that the prefix and the instruction that uses it are never separated.

Top module: `operand_override`

## Requirements
- R1: After reset the buffer is empty: `irq_block` is 0, and `opnd` equals `rf_rdata` for any file-reading kind.
- R2: An executed register prefix (`op_kind`=4) captures `rf_rdata`. In the next valid slot `opnd` equals the captured value and `rf_rd_en` is 0.
- R3: An executed literal prefix (`op_kind`=5) captures `op_lit`, and the next valid slot uses that value as its operand.
- R4: The add kind (`op_kind`=1) gives `res` = `wreg` + `opnd` modulo 2^W, and asserts `dst_we` and `flag_we`. With `wreg`=5 and a register prefix that captured value A, the add writes A+5.
- R5: The no-flags move (`op_kind`=3) gives `res` = `opnd` and asserts `dst_we`, while `flag_we` and `acc_we` stay 0.
- R6: A prefix slot asserts none of `dst_we`, `acc_we` and `flag_we`.
- R7: A skipped slot (`slot_skip`=1) asserts no write enable. A skipped prefix does not arm the buffer. A skipped literal prefix followed by a no-flags move therefore writes back the destination's own value.
- R8: The override lasts for exactly one valid slot, whether that slot executes or is skipped. After that slot, `opnd` follows `rf_rdata` again.
- R9: While the buffer is armed `irq_block` is 1. A cycle with `slot_valid`=0 keeps both the buffer and its value.
- R10: A prefix in an armed slot re-arms the buffer. A register prefix re-arms with the buffered value, and a literal prefix re-arms with its own literal.
- R11: The normal move to the accumulator (`op_kind`=2) gives `res` = `opnd` and asserts `acc_we` and `flag_we`. Kind 0 reads no file operand and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | An instruction occupies the execute slot |
| slot_skip | input | 1 | The instruction in the slot is being skipped |
| op_kind | input | 3 | Decoded kind: 0 other, 1 add, 2 move to accumulator, 3 no-flags move, 4 register prefix, 5 literal prefix |
| op_lit | input | W | Literal field of the opcode |
| rf_rdata | input | W | Register file read data for the addressed register |
| wreg | input | W | Accumulator value |
| rf_rd_en | output | 1 | The file operand read is needed this slot |
| opnd | output | W | Operand sent to the ALU |
| res | output | W | Result for the add and move kinds |
| dst_we | output | 1 | Write the destination file register |
| acc_we | output | 1 | Write the accumulator |
| flag_we | output | 1 | Update the status flags |
| irq_block | output | 1 | Interrupt entry must wait |

## Verification
Two things can happen in the same slot: a slot uses the buffered operand, and that same slot is a prefix that captures a new value. Either one can also fall on a skipped slot. The bench makes these cases happen with back-to-back prefixes and with skipped consumers, and it runs a random instruction stream that mixes skips and bubbles. A reference model in the bench works out, cycle by cycle, which value must be in the buffer afterwards. The outputs are compared against it on every clock.

// File: rtl/operand_override.sv
module operand_override #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_valid,
  input  logic         slot_skip,
  input  logic [2:0]   op_kind,
  input  logic [W-1:0] op_lit,
  input  logic [W-1:0] rf_rdata,
  input  logic [W-1:0] wreg,
  output logic         rf_rd_en,
  output logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         dst_we,
  output logic         acc_we,
  output logic         flag_we,
  output logic         irq_block
);
  localparam logic [2:0] K_ADD   = 3'd1;
  localparam logic [2:0] K_MOVF  = 3'd2;
  localparam logic [2:0] K_MOVNF = 3'd3;
  localparam logic [2:0] K_PREG  = 3'd4;
  localparam logic [2:0] K_PLIT  = 3'd5;

  logic         armed;
  logic [W-1:0] held;
  logic         run;
  logic         reads_file;

  assign run        = slot_valid && !slot_skip;
  assign reads_file = op_kind inside {K_ADD, K_MOVF, K_MOVNF, K_PREG};

  assign opnd      = armed ? held : rf_rdata;
  assign rf_rd_en  = slot_valid && reads_file && !armed;
  assign res       = (op_kind == K_ADD) ? W'(wreg + opnd) : opnd;
  assign dst_we    = run && (op_kind == K_ADD || op_kind == K_MOVNF);
  assign acc_we    = run && (op_kind == K_MOVF);
  assign flag_we   = run && (op_kind == K_ADD || op_kind == K_MOVF);
  assign irq_block = armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      held  <= '0;
    end else if (slot_valid) begin
      if (run && op_kind == K_PREG) begin
        armed <= 1'b1;
        held  <= opnd;
      end else if (run && op_kind == K_PLIT) begin
        armed <= 1'b1;
        held  <= op_lit;
      end else begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/operand_override_chk.sv
module operand_override_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         slot_valid,
  input logic         slot_skip,
  input logic [2:0]   op_kind,
  input logic [W-1:0] op_lit,
  input logic         rf_rd_en,
  input logic [W-1:0] opnd,
  input logic         dst_we,
  input logic         acc_we,
  input logic         flag_we,
  input logic         irq_block
);
  assert_lit_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_skip && op_kind == 3'd5) |=> (irq_block && opnd == $past(op_lit)));

  assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && (slot_skip || !(op_kind inside {3'd4, 3'd5}))) |=> !irq_block);

  assert_hold_on_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_valid && irq_block) |=> (irq_block && $stable(opnd)));

  assert_no_file_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && irq_block) |-> !rf_rd_en);

  assert_noflag_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && op_kind == 3'd3) |-> (!flag_we && !acc_we));

  assert_prefix_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind inside {3'd4, 3'd5}) |-> (!dst_we && !acc_we && !flag_we));

  assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_skip |-> (!dst_we && !acc_we && !flag_we));

  assert_skipped_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_skip) |=> !irq_block);
endmodule

bind operand_override operand_override_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_skip(slot_skip),
  .op_kind(op_kind), .op_lit(op_lit), .rf_rd_en(rf_rd_en), .opnd(opnd),
  .dst_we(dst_we), .acc_we(acc_we), .flag_we(flag_we), .irq_block(irq_block)
);

// File: tb/tb_operand_override.sv
module tb_operand_override;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         slot_valid = 1'b0;
  logic         slot_skip = 1'b0;
  logic [2:0]   op_kind = 3'd0;
  logic [W-1:0] op_lit = '0;
  logic [W-1:0] rf_rdata = '0;
  logic [W-1:0] wreg = '0;
  logic         rf_rd_en, dst_we, acc_we, flag_we, irq_block;
  logic [W-1:0] opnd, res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_armed = 0;
  int m_buf = 0;

  always #2 clk = ~clk;

  operand_override #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_skip(slot_skip),
    .op_kind(op_kind), .op_lit(op_lit), .rf_rdata(rf_rdata), .wreg(wreg),
    .rf_rd_en(rf_rd_en), .opnd(opnd), .res(res), .dst_we(dst_we),
    .acc_we(acc_we), .flag_we(flag_we), .irq_block(irq_block)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int v, int s, int k, int l, int r, int w, string req);
    int e_op, e_res, ex;
    slot_valid = v[0]; slot_skip = s[0]; op_kind = k[2:0];
    op_lit = l[W-1:0]; rf_rdata = r[W-1:0]; wreg = w[W-1:0];
    #1;
    ex   = (v != 0 && s == 0) ? 1 : 0;
    e_op = (m_armed != 0) ? m_buf : (r & 255);
    e_res = (k == 1) ? ((w + e_op) & 255) : e_op;
    chk(req, "irq_block", int'(irq_block), m_armed);
    chk(req, "opnd", int'(opnd), e_op);
    chk(req, "rf_rd_en", int'(rf_rd_en),
        (v != 0 && k >= 1 && k <= 4 && m_armed == 0) ? 1 : 0);
    if (k == 1 || k == 2 || k == 3) chk(req, "res", int'(res), e_res);
    chk(req, "dst_we", int'(dst_we), (ex != 0 && (k == 1 || k == 3)) ? 1 : 0);
    chk(req, "acc_we", int'(acc_we), (ex != 0 && k == 2) ? 1 : 0);
    chk(req, "flag_we", int'(flag_we), (ex != 0 && (k == 1 || k == 2)) ? 1 : 0);
    @(posedge clk);
    if (v != 0) begin
      if (ex != 0 && k == 4) begin m_armed = 1; m_buf = e_op; end
      else if (ex != 0 && k == 5) begin m_armed = 1; m_buf = l & 255; end
      else m_armed = 0;
    end
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(1, 0, 1, 0, 8'h42, 1, "R1");
    cyc(1, 0, 4, 0, 8'h33, 0, "R2");
    cyc(1, 0, 1, 0, 8'h99, 5, "R4");
    cyc(1, 0, 1, 0, 8'h10, 5, "R8");
    cyc(1, 0, 5, 8'h28, 8'h77, 9, "R3");
    cyc(1, 0, 3, 0, 8'h61, 9, "R5");
    cyc(1, 1, 5, 8'h28, 8'h00, 9, "R7");
    cyc(1, 0, 3, 0, 8'h61, 9, "R7");
    cyc(1, 0, 4, 0, 8'hA5, 0, "R6");
    cyc(1, 1, 3, 0, 8'h12, 0, "R8");
    cyc(1, 0, 3, 0, 8'h12, 0, "R8");
    cyc(1, 0, 5, 8'h3C, 0, 0, "R9");
    cyc(0, 0, 1, 0, 8'hEE, 0, "R9");
    cyc(0, 0, 0, 0, 8'hDD, 0, "R9");
    cyc(1, 0, 2, 0, 8'hCC, 0, "R9");
    cyc(1, 0, 5, 8'h11, 0, 0, "R10");
    cyc(1, 0, 4, 0, 8'h99, 0, "R10");
    cyc(1, 0, 5, 8'h22, 0, 0, "R10");
    cyc(1, 0, 1, 0, 8'h01, 8'hFF, "R4");
    cyc(1, 0, 2, 0, 8'h5A, 0, "R11");
    cyc(1, 0, 0, 0, 8'h5A, 0, "R11");
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 5) != 0, ($urandom % 4) == 0, $urandom % 6,
          $urandom % 256, $urandom % 256, $urandom % 256, "R8");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule